// File: doc/BRIEF.md
# Checkerboard Two-Phase Lookup-Cell Array

This block is a rectangular array of tiny lookup-table cells. There is no routing fabric. Every cell exchanges exactly one bit with each of its four orthogonal neighbours. It reads one bit from each side and drives one bit back to each side.

Each cell is controlled by a 64-bit program word. The word holds four 16-entry truth tables, one for each outgoing direction. The four incoming bits select the entry.

Cells are coloured like a chessboard, so each neighbour of a cell belongs to the other colour. Class A cells sit where (x + y) is even, and class B cells where (x + y) is odd. Because of this, every cell of one class can be evaluated at the same time. Their inputs come only from registers of the other class, and those registers are frozen during that phase.

A host stops stepping and loads programs one cell at a time through a valid/ready port. It then applies boundary bits and pulses `step`. Each pulse advances the array by one phase. Class A is evaluated first after reset, then class B, and the two alternate from there.

The array dimensions are parameters and must both be even. Cell (x, y) has row y = 0 at the north edge and column x = 0 at the west edge. Its linear address is y*GRID_W + x.

Program-load handshake: a word is written in a cycle where `prog_valid` and `prog_ready` are both high. `prog_ready` is low in every cycle where `step` is high. A source that holds `prog_valid`, `prog_addr` and `prog_data` through such a cycle has its write completed in the next cycle where `step` is low. Nothing is written while `prog_valid` is low.

Top module: `lut_grid`

## Requirements
- R1: After reset every program word and every cell output register is zero, so all edge outputs are 0. `phase_o` is 0 and `prog_ready` is 1 while `step` is low.
- R2: A cell forms a 4-bit index {N, E, S, W}, with the north input as the MSB and the west input as the LSB. On evaluation, its output toward direction d (0 = north, 1 = east, 2 = south, 3 = west) takes program bit [d*16 + index].
- R3: A step pulse while `phase_o` is 0 evaluates only class A cells ((x + y) even). A pulse while `phase_o` is 1 evaluates only class B cells ((x + y) odd). The new outputs are visible after the clock edge that samples the pulse.
- R4: Each clock cycle with `step` high toggles `phase_o` exactly once. Cycles with `step` low leave it unchanged.
- R5: A cell's output registers keep their value through any cycle in which that cell is not evaluated.
- R6: A program write at linear address y*GRID_W + x replaces that cell's word only in a cycle where `prog_valid` and `prog_ready` are both high. `prog_ready` is low whenever `step` is high, and an offered write in such a cycle changes no word.
- R7: A neighbour input that lies off the array comes from the matching edge input bit: `edge_n_in[x]`, `edge_s_in[x]`, `edge_w_in[y]` or `edge_e_in[y]`. An output pointing off the array drives the matching edge output bit.
- R8: Loading a new program does not change a cell's outputs. The new word takes effect only at that cell's next evaluation.
- R9: Signals travel through the array one cell per phase. A value entering at the north edge of cell (0,0) and relayed eastward along row 0 reaches `edge_e_out[0]` after four phases on a 4-wide array, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | Advance one phase in this cycle |
| phase_o | output | 1 | Class evaluated by the next step: 0 = A, 1 = B |
| prog_valid | input | 1 | Program write offered |
| prog_ready | output | 1 | Program write can be taken this cycle |
| prog_addr | input | $clog2(GRID_W*GRID_H) | Linear cell address y*GRID_W + x |
| prog_data | input | 64 | Program word, four 16-entry tables |
| edge_n_in | input | GRID_W | Bits fed into row 0 north inputs |
| edge_s_in | input | GRID_W | Bits fed into the last row's south inputs |
| edge_w_in | input | GRID_H | Bits fed into column 0 west inputs |
| edge_e_in | input | GRID_H | Bits fed into the last column's east inputs |
| edge_n_out | output | GRID_W | North outputs of row 0 |
| edge_s_out | output | GRID_W | South outputs of the last row |
| edge_w_out | output | GRID_H | West outputs of column 0 |
| edge_e_out | output | GRID_H | East outputs of the last column |

## Verification
The bench programs the north-west corner cell with a series of words and edge inputs. It checks the north and west outputs against the index rule. A design that swapped the index bit order or the direction slices would read the wrong table entry.

It places an all-ones program in a class B cell and checks that the cell stays silent on an A step. A parity error would make the cell fire one phase early.

A write offered during a step must be dropped. A design that ignored back-pressure would clear a word that the next B step shows is still there. A write while halted must not disturb the outputs until the cell is next evaluated.

A relay along row 0 checks the one-cell-per-phase propagation. A design that evaluated both classes together would deliver the bit to the east edge too early. A south-east corner check covers the east-in and south-out edge wiring.

// File: rtl/lutg_pkg.sv
package lutg_pkg;
  localparam int DIRS    = 4;
  localparam int ENTRIES = 16;
  localparam int PROG_W  = DIRS * ENTRIES;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  typedef logic [PROG_W-1:0] prog_t;

  // Evaluate all four direction tables for one input index.
  function automatic logic [DIRS-1:0] lut_eval(prog_t p, logic [3:0] idx);
    logic [DIRS-1:0] r;
    for (int d = 0; d < DIRS; d++) begin
      r[d] = p[d*ENTRIES + int'(idx)];
    end
    return r;
  endfunction
endpackage

// File: rtl/lutg_phase.sv
module lutg_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic phase_q,
  output logic eval_a,
  output logic eval_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else if (step) phase_q <= ~phase_q;
  end

  assign eval_a = step & ~phase_q;
  assign eval_b = step &  phase_q;

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (phase_q != $past(phase_q))); // R4
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase_q)); // R4
endmodule

// File: rtl/lutg_cell.sv
module lutg_cell
  import lutg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  prog_t           wr_data,
  input  logic            eval_en,
  input  logic [DIRS-1:0] nbr_in,   // indexed by dir_e
  output logic [DIRS-1:0] out_q     // indexed by dir_e
);
  prog_t      prog_q;
  logic [3:0] idx;

  // Index {N, E, S, W}, north as MSB
  assign idx = {nbr_in[DIR_N], nbr_in[DIR_E], nbr_in[DIR_S], nbr_in[DIR_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= '0;
    else if (wr_en) prog_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (eval_en) out_q <= lut_eval(prog_q, idx);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |=> $stable(out_q)); // R5
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prog_q)); // R6
endmodule

// File: rtl/lut_grid.sv
module lut_grid
  import lutg_pkg::*;
#(
  parameter int GRID_W = 4,
  parameter int GRID_H = 4,
  localparam int NCELL = GRID_W * GRID_H,
  localparam int AW    = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic              phase_o,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic [AW-1:0]     prog_addr,
  input  logic [PROG_W-1:0] prog_data,
  input  logic [GRID_W-1:0] edge_n_in,
  input  logic [GRID_W-1:0] edge_s_in,
  input  logic [GRID_H-1:0] edge_w_in,
  input  logic [GRID_H-1:0] edge_e_in,
  output logic [GRID_W-1:0] edge_n_out,
  output logic [GRID_W-1:0] edge_s_out,
  output logic [GRID_H-1:0] edge_w_out,
  output logic [GRID_H-1:0] edge_e_out
);
  initial begin
    if ((GRID_W % 2) != 0 || (GRID_H % 2) != 0)
      $error("lut_grid: GRID_W and GRID_H must be even");
  end

  logic eval_a, eval_b, wr_go;
  logic [DIRS-1:0] cout [NCELL];
  logic [DIRS-1:0] cin  [NCELL];

  lutg_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .phase_q(phase_o),
    .eval_a (eval_a),
    .eval_b (eval_b)
  );

  assign prog_ready = ~step;
  assign wr_go      = prog_valid & prog_ready;

  for (genvar gy = 0; gy < GRID_H; gy++) begin : g_row
    for (genvar gx = 0; gx < GRID_W; gx++) begin : g_col
      localparam int C       = gy*GRID_W + gx;
      localparam bit CLASS_B = ((gx + gy) % 2) == 1;

      // north input
      if (gy == 0) begin : g_n_edge
        assign cin[C][DIR_N] = edge_n_in[gx];
        assign edge_n_out[gx] = cout[C][DIR_N];
      end else begin : g_n_int
        assign cin[C][DIR_N] = cout[C-GRID_W][DIR_S];
      end
      // south input
      if (gy == GRID_H-1) begin : g_s_edge
        assign cin[C][DIR_S] = edge_s_in[gx];
        assign edge_s_out[gx] = cout[C][DIR_S];
      end else begin : g_s_int
        assign cin[C][DIR_S] = cout[C+GRID_W][DIR_N];
      end
      // west input
      if (gx == 0) begin : g_w_edge
        assign cin[C][DIR_W] = edge_w_in[gy];
        assign edge_w_out[gy] = cout[C][DIR_W];
      end else begin : g_w_int
        assign cin[C][DIR_W] = cout[C-1][DIR_E];
      end
      // east input
      if (gx == GRID_W-1) begin : g_e_edge
        assign cin[C][DIR_E] = edge_e_in[gy];
        assign edge_e_out[gy] = cout[C][DIR_E];
      end else begin : g_e_int
        assign cin[C][DIR_E] = cout[C+1][DIR_W];
      end

      lutg_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_go && (prog_addr == AW'(C))),
        .wr_data(prog_data),
        .eval_en(CLASS_B ? eval_b : eval_a),
        .nbr_in (cin[C]),
        .out_q  (cout[C])
      );
    end
  end

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eval_a, eval_b})); // R3
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(edge_n_out) && $stable(edge_s_out)
               && $stable(edge_w_out) && $stable(edge_e_out))); // R5
endmodule

// File: tb/lut_grid_test.sv
`timescale 1ns/1ps
module lut_grid_test;
  localparam int W  = 4;
  localparam int H  = 4;
  localparam int AW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic step = 0;
  logic phase_o, prog_valid = 0, prog_ready;
  logic [AW-1:0] prog_addr = '0;
  logic [63:0] prog_data = '0;
  logic [W-1:0] edge_n_in = '0, edge_s_in = '0, edge_n_out, edge_s_out;
  logic [H-1:0] edge_w_in = '0, edge_e_in = '0, edge_w_out, edge_e_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lut_grid #(.GRID_W(W), .GRID_H(H)) uut (
    .clk(clk), .rst_n(rst_n), .step(step), .phase_o(phase_o),
    .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .edge_n_in(edge_n_in), .edge_s_in(edge_s_in),
    .edge_w_in(edge_w_in), .edge_e_in(edge_e_in),
    .edge_n_out(edge_n_out), .edge_s_out(edge_s_out),
    .edge_w_out(edge_w_out), .edge_e_out(edge_e_out)
  );

  // Table: program word for cell (0,0), north edge bit, west edge bit
  typedef struct packed { logic [63:0] word; logic n; logic w; } vec_t;
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0001_0000_0000_0001, 1'b0, 1'b0},
    '{64'h0100_0000_0000_0100, 1'b1, 1'b0},
    '{64'h0002_0000_0000_0002, 1'b0, 1'b1},
    '{64'h0200_0000_0000_0001, 1'b1, 1'b1},
    '{64'hFDFF_0000_0000_FFFE, 1'b0, 1'b0},
    '{64'h0000_FFFF_FFFF_0200, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_step();
    @(negedge clk); step = 1;
    @(negedge clk); step = 0;
  endtask

  task automatic write_prog(input int addr, input logic [63:0] word);
    @(negedge clk);
    prog_valid = 1; prog_addr = AW'(addr); prog_data = word;
    @(negedge clk);
    prog_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 edge_n_out", edge_n_out, 0);
    check("R1 edge_s_out", edge_s_out, 0);
    check("R1 edge_w_out", edge_w_out, 0);
    check("R1 edge_e_out", edge_e_out, 0);
    check("R1 phase", phase_o, 0);
    check("R1 ready", prog_ready, 1);

    // R2 table walk on corner cell (class A); idx = {n,0,0,w}
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] idx;
      write_prog(0, VECS[i].word);
      edge_n_in[0] = VECS[i].n;
      edge_w_in[0] = VECS[i].w;
      idx = {VECS[i].n, 1'b0, 1'b0, VECS[i].w};
      check("R4 phase before A", phase_o, 0);
      do_step();
      check("R2 north out", edge_n_out[0], VECS[i].word[0*16 + idx]);
      check("R2 west out",  edge_w_out[0], VECS[i].word[3*16 + idx]);
      check("R4 phase after A", phase_o, 1);
      do_step();
      check("R5 north held over B", edge_n_out[0], VECS[i].word[0*16 + idx]);
      check("R5 west held over B",  edge_w_out[0], VECS[i].word[3*16 + idx]);
    end
    edge_n_in = '0; edge_w_in = '0;

    // R3 class B cell (1,0) programmed all ones
    write_prog(1, '1);
    do_step();
    check("R3 class B idle on A step", edge_n_out[1], 0);
    do_step();
    check("R3 class B fires on B step", edge_n_out[1], 1);

    // R6 write offered during a step is dropped
    @(negedge clk);
    step = 1; prog_valid = 1; prog_addr = AW'(1); prog_data = '0;
    #1 check("R6 ready low during step", prog_ready, 0);
    @(negedge clk);
    step = 0; prog_valid = 0;
    do_step();
    check("R6 blocked write ignored", edge_n_out[1], 1);

    // R8 write while halted does not touch outputs
    write_prog(1, '0);
    check("R8 output unchanged by write", edge_n_out[1], 1);
    do_step();
    do_step();
    check("R8 new word after evaluation", edge_n_out[1], 0);

    // R9 / R7 relay along row 0: (0,0) E=N, others E=W
    write_prog(0, 64'h0000_0000_FF00_0000);
    write_prog(1, 64'h0000_0000_AAAA_0000);
    write_prog(2, 64'h0000_0000_AAAA_0000);
    write_prog(3, 64'h0000_0000_AAAA_0000);
    edge_n_in[0] = 1;
    do_step(); do_step();
    check("R9 relay not early", edge_e_out[0], 0);
    do_step(); do_step();
    check("R9 relay arrives", edge_e_out[0], 1);

    // R7 south-east corner (3,3), class A: S = E input
    write_prog(15, 64'h0000_F0F0_0000_0000);
    edge_e_in[3] = 1;
    do_step();
    check("R7 east in to south out", edge_s_out[3], 1);
    do_step();
    edge_e_in[3] = 0;
    do_step();
    check("R7 east in low", edge_s_out[3], 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule